// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block sits beside the command engine of a serial non-volatile memory. It holds the status byte that the host reads back and rules on each array write and each status write: a request is granted only when the write-enable latch is set, the target is outside the protected region, and, for a status write, the hardware lock is not engaged. A granted request starts a program cycle, and the block reports busy until the engine signals that the cycle has finished. The engine drives the latch commands, the requests and the completion strobe. It uses the grant and deny strobes to start or drop the operation.

The protection fields (lock-enable bit and the two region bits) model non-volatile cells. Only the power-up reset `por_n` loads them, to their delivery value of zero. The soft reset `soft_rst_n` clears only the volatile state: the latch, the busy flag and the controller state.

Controller states: `ST_IDLE` (waiting; grants or denies requests), `ST_ARR_PROG` (array program cycle in progress), `ST_STS_PROG` (status program cycle in progress). Transitions: `ST_IDLE`→`ST_ARR_PROG` on a granted array write; `ST_IDLE`→`ST_STS_PROG` on a granted status write; `ST_ARR_PROG`→`ST_IDLE` and `ST_STS_PROG`→`ST_IDLE` on `prog_done`. Any reset returns to `ST_IDLE`.

Top module: `srwp_unit`

## Requirements
- R1: After `por_n` is low at a clock edge, `status_byte` reads 0x00. A soft reset clears the latch and busy but keeps the lock-enable bit and both region bits.
- R2: `status_byte` layout: bit 7 is the lock-enable bit, bits 3:2 are the region code, bit 1 is the write-enable latch, bit 0 is busy, and bits 6:4 and the other unused bits read 0.
- R3: When idle, `set_wel` sets the latch and `clr_wel` clears it. If both are high in the same cycle, the clear wins. While busy, both commands have no effect on the latch.
- R4: An array or status write requested while the latch is clear is denied in that same cycle, and no program cycle starts.
- R5: The region code selects the protected addresses. 00 protects none. 01 protects the upper quarter (two address MSBs equal 11; 0x1800–0x1FFF at the default 13-bit address). 10 protects the upper half (address MSB 1; 0x1000–0x1FFF). 11 protects the whole array.
- R6: An array write to a protected address is denied without starting a program cycle, and the latch stays set.
- R7: A granted array write sets busy from the next cycle until the edge at which `prog_done` is seen. At that edge, busy and the latch both clear.
- R8: A granted status write captures `sr_data[7]` and `sr_data[3:2]`. Until the completing edge, the status byte shows the old protection fields. At that edge, the new fields appear and the latch clears.
- R9: With the lock-enable bit at 1 and `wp_n` low, a status write is denied and the latch stays set. With `wp_n` high, it is granted.
- R10: While busy, every array or status request is denied.
- R11: If an array write and a status write arrive together while idle, the status write is served and the array write is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous; also loads the non-volatile fields |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous; volatile state only |
| wp_n | input | 1 | Write-protect pin, active low |
| set_wel | input | 1 | Set write-enable latch command |
| clr_wel | input | 1 | Clear write-enable latch command |
| wr_req | input | 1 | Array write request |
| wr_addr | input | ADDR_W | Array write target address |
| sr_req | input | 1 | Status write request |
| sr_data | input | 8 | Status write data byte |
| prog_done | input | 1 | Program cycle finished |
| grant_wr | output | 1 | Array write granted (combinational) |
| deny_wr | output | 1 | Array write refused (combinational) |
| grant_sr | output | 1 | Status write granted (combinational) |
| deny_sr | output | 1 | Status write refused (combinational) |
| busy | output | 1 | Program cycle in progress |
| status_byte | output | 8 | Status byte for readout |

## Verification
Two cases can fall in the same cycle. The first is the arbitration between an array write and a status write arriving together. The bench raises both requests in one idle cycle and expects the status grant, the array deny, and afterwards only the status fields changing. The second is a latch command landing during a program cycle. A clear command sent while busy must leave the latch bit set in the status byte until `prog_done`, and a simultaneous set and clear while idle must leave it clear.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARR_PROG = 2'd1,
        ST_STS_PROG = 2'd2
    } srwp_state_e;

    localparam int SB_LOCK  = 7;
    localparam int SB_BP_HI = 3;
    localparam int SB_BP_LO = 2;
    localparam int SB_WEL   = 1;
    localparam int SB_BUSY  = 0;
endpackage

// File: rtl/srwp_region_cmp.sv
module srwp_region_cmp #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (addr[TOP -: 2] == 2'b11);
            2'b10:   hit = addr[TOP];
            default: hit = 1'b1;
        endcase
    end

    always_comb begin
        if (bp == 2'b00) AST_NONE_NO_HIT: assert (!hit); // R5
    end
endmodule

// File: rtl/srwp_nv_bits.sv
module srwp_nv_bits (
    input  logic       clk,
    input  logic       por_n,
    input  logic       commit,
    input  logic       new_lock,
    input  logic [1:0] new_bp,
    output logic       lock_en,
    output logic [1:0] bp
);
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lock_en <= 1'b0;
            bp      <= 2'b00;
        end else if (commit) begin
            lock_en <= new_lock;
            bp      <= new_bp;
        end
    end
endmodule

// File: rtl/srwp_unit.sv
module srwp_unit #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic              wp_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              sr_req,
    input  logic [7:0]        sr_data,
    input  logic              prog_done,
    output logic              grant_wr,
    output logic              deny_wr,
    output logic              grant_sr,
    output logic              deny_sr,
    output logic              busy,
    output logic [7:0]        status_byte
);
    import srwp_pkg::*;

    srwp_state_e state, state_nx;
    logic        vrst;
    logic        wel;
    logic        lock_en;
    logic [1:0]  bp;
    logic        pend_lock;
    logic [1:0]  pend_bp;
    logic        prot_hit;
    logic        sr_locked;
    logic        commit;

    assign vrst      = !por_n || !soft_rst_n;
    assign sr_locked = lock_en && !wp_n;
    assign busy      = (state != ST_IDLE);

    srwp_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .bp   (bp),
        .addr (wr_addr),
        .hit  (prot_hit)
    );

    srwp_nv_bits u_nv (
        .clk      (clk),
        .por_n    (por_n),
        .commit   (commit),
        .new_lock (pend_lock),
        .new_bp   (pend_bp),
        .lock_en  (lock_en),
        .bp       (bp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (vrst) state <= ST_IDLE;
        else      state <= state_nx;
    end

    // next state and strobes
    always_comb begin
        state_nx = state;
        grant_wr = 1'b0;
        deny_wr  = 1'b0;
        grant_sr = 1'b0;
        deny_sr  = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sr_req) begin
                    if (wel && !sr_locked) begin
                        grant_sr = 1'b1;
                        state_nx = ST_STS_PROG;
                    end else begin
                        deny_sr = 1'b1;
                    end
                end
                if (wr_req) begin
                    if (!sr_req && wel && !prot_hit) begin
                        grant_wr = 1'b1;
                        state_nx = ST_ARR_PROG;
                    end else begin
                        deny_wr = 1'b1;
                    end
                end
            end
            ST_ARR_PROG: begin
                deny_wr = wr_req;
                deny_sr = sr_req;
                if (prog_done) state_nx = ST_IDLE;
            end
            ST_STS_PROG: begin
                deny_wr = wr_req;
                deny_sr = sr_req;
                if (prog_done) begin
                    state_nx = ST_IDLE;
                    commit   = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // write-enable latch
    always_ff @(posedge clk) begin
        if (vrst) begin
            wel <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (prog_done) wel <= 1'b0;
        end else if (clr_wel) begin
            wel <= 1'b0;
        end else if (set_wel) begin
            wel <= 1'b1;
        end
    end

    // pending protection fields of a granted status write
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pend_lock <= 1'b0;
            pend_bp   <= 2'b00;
        end else if (grant_sr) begin
            pend_lock <= sr_data[SB_LOCK];
            pend_bp   <= sr_data[SB_BP_HI:SB_BP_LO];
        end
    end

    always_comb begin
        status_byte          = 8'h00;
        status_byte[SB_LOCK] = lock_en;
        status_byte[SB_BP_HI:SB_BP_LO] = bp;
        status_byte[SB_WEL]  = wel;
        status_byte[SB_BUSY] = busy;
    end

    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (vrst)
        (grant_wr || grant_sr) |-> wel); // R4
    AST_NO_PROT_GRANT: assert property (@(posedge clk) disable iff (vrst)
        grant_wr |-> !prot_hit); // R6
    AST_LOCK_BLOCKS_SR: assert property (@(posedge clk) disable iff (vrst)
        grant_sr |-> !(lock_en && !wp_n)); // R9
    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (vrst)
        (busy && prog_done) |=> (!wel && !busy)); // R7
    AST_BP_HELD_IN_PROG: assert property (@(posedge clk) disable iff (vrst)
        (state == ST_STS_PROG && !prog_done) |=> $stable(bp)); // R8
    AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (vrst)
        busy |-> !(grant_wr || grant_sr)); // R10
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (vrst)
        $countones({grant_wr, grant_sr}) <= 1); // R11
endmodule

// File: tb/tb_srwp_unit.sv
module tb_srwp_unit;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          por_n, soft_rst_n, wp_n, set_wel, clr_wel;
    logic          wr_req, sr_req, prog_done;
    logic [AW-1:0] wr_addr;
    logic [7:0]    sr_data;
    logic          grant_wr, deny_wr, grant_sr, deny_sr, busy;
    logic [7:0]    status_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    srwp_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .wp_n(wp_n),
        .set_wel(set_wel), .clr_wel(clr_wel), .wr_req(wr_req), .wr_addr(wr_addr),
        .sr_req(sr_req), .sr_data(sr_data), .prog_done(prog_done),
        .grant_wr(grant_wr), .deny_wr(deny_wr), .grant_sr(grant_sr),
        .deny_sr(deny_sr), .busy(busy), .status_byte(status_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic model_prot(input logic [1:0] code, input logic [AW-1:0] a);
        case (code)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'h1800;
            2'b10:   return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic idle_inputs();
        set_wel = 0; clr_wel = 0; wr_req = 0; sr_req = 0; prog_done = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wel_on();
        set_wel = 1; step();
    endtask

    // full status write, expects grant
    task automatic sr_write(input logic [7:0] d);
        wel_on();
        sr_req = 1; sr_data = d; #1;
        chk("R8 grant", grant_sr, 1);
        step();
        prog_done = 1; step();
    endtask

    task automatic t_reset();
        por_n = 0; soft_rst_n = 1; wp_n = 1; wr_addr = '0; sr_data = 8'h00;
        idle_inputs();
        step(); step();
        por_n = 1; step();
        chk("R1 por status", status_byte, 8'h00);
        chk("R1 por busy", busy, 0);
    endtask

    task automatic t_wel();
        wel_on();
        chk("R3 set", status_byte, 8'h02);
        chk("R2 wel bit1", status_byte[1], 1);
        clr_wel = 1; step();
        chk("R3 clear", status_byte, 8'h00);
        wel_on();
        set_wel = 1; clr_wel = 1; step();
        chk("R3 clear wins", status_byte, 8'h00);
    endtask

    task automatic t_no_wel();
        wr_req = 1; wr_addr = 13'h0010; #1;
        chk("R4 wr deny", deny_wr, 1);
        chk("R4 wr grant", grant_wr, 0);
        step();
        chk("R4 no busy", busy, 0);
        sr_req = 1; sr_data = 8'h0C; #1;
        chk("R4 sr deny", deny_sr, 1);
        step();
        chk("R4 sr no effect", status_byte, 8'h00);
    endtask

    task automatic t_status_write();
        wel_on();
        sr_req = 1; sr_data = 8'h74; #1;
        chk("R8 grant", grant_sr, 1);
        step();
        chk("R8 old fields", status_byte, 8'h03);
        sr_req = 1; #1;
        chk("R10 sr deny busy", deny_sr, 1);
        step();
        chk("R8 still old", status_byte, 8'h03);
        prog_done = 1; step();
        chk("R8 committed", status_byte, 8'h04);
        chk("R2 unused zero", status_byte[6:4], 0);
    endtask

    task automatic t_protect();
        logic [AW-1:0] addrs [6] = '{13'h0000, 13'h0FFF, 13'h1000, 13'h17FF, 13'h1800, 13'h1FFF};
        for (int c = 0; c < 4; c++) begin
            sr_write({4'h0, c[1:0], 2'b00});
            chk("R5 code set", status_byte, {4'h0, c[1:0], 2'b00});
            for (int i = 0; i < 6; i++) begin
                logic p;
                p = model_prot(c[1:0], addrs[i]);
                wel_on();
                wr_req = 1; wr_addr = addrs[i]; #1;
                chk("R5 grant", grant_wr, !p);
                chk("R6 deny", deny_wr, p);
                step();
                if (p) begin
                    chk("R6 no prog, wel kept", status_byte, {4'h0, c[1:0], 2'b10});
                    clr_wel = 1; step();
                end else begin
                    chk("R7 busy", status_byte, {4'h0, c[1:0], 2'b11});
                    clr_wel = 1; wr_req = 1; #1;
                    chk("R10 wr deny busy", deny_wr, 1);
                    step();
                    chk("R3 clr ignored busy", status_byte[1], 1);
                    prog_done = 1; step();
                    chk("R7 done", status_byte, {4'h0, c[1:0], 2'b00});
                end
            end
        end
        sr_write(8'h00);
    endtask

    task automatic t_lock();
        sr_write(8'h80);
        chk("R2 lock bit7", status_byte, 8'h80);
        wp_n = 0;
        wel_on();
        sr_req = 1; sr_data = 8'h00; #1;
        chk("R9 deny locked", deny_sr, 1);
        step();
        chk("R9 wel kept", status_byte, 8'h82);
        wp_n = 1;
        sr_req = 1; sr_data = 8'h00; #1;
        chk("R9 grant unlocked", grant_sr, 1);
        step();
        prog_done = 1; step();
        chk("R9 cleared", status_byte, 8'h00);
    endtask

    task automatic t_same_cycle();
        wel_on();
        sr_req = 1; sr_data = 8'h08; wr_req = 1; wr_addr = 13'h0001; #1;
        chk("R11 sr grant", grant_sr, 1);
        chk("R11 wr deny", deny_wr, 1);
        step();
        prog_done = 1; step();
        chk("R11 result", status_byte, 8'h08);
    endtask

    task automatic t_soft();
        sr_write(8'h88);
        wel_on();
        soft_rst_n = 0; step();
        soft_rst_n = 1; step();
        chk("R1 soft keeps nv", status_byte, 8'h88);
        por_n = 0; step();
        por_n = 1; step();
        chk("R1 por clears nv", status_byte, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wel();
        t_no_wel();
        t_status_write();
        t_protect();
        t_lock();
        t_same_cycle();
        t_soft();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule